// File: doc/BRIEF.md
# Dual-Law PCM Compander

This block converts between linear two's-complement voice samples and 8-bit companded PCM codes, in both directions at once. An encode path takes a 14-bit linear sample and returns one 8-bit code. A decode path takes one 8-bit code and returns a 14-bit linear sample. Each path has its own valid strobe on the input and on the output, with one clock of latency between them.

One select input chooses the companding law for both paths. Low selects mu-law, and a board-level pull-down should hold it low when it is not driven. High selects A-law. The A-law wire format, with its even-bit inversion, comes out of the same datapath, so one instance serves either kind of line. In A-law the linear port carries a 13-bit sample left-justified: bit 0 is ignored on encode and returns as zero on decode.

Top module: `pcm_compander`

## Requirements
- R1: While `rst_ni` is low, `enc_valid_o` and `dec_valid_o` are both 0.
- R2: `alaw_sel_i` = 0 selects mu-law and 1 selects A-law for both paths. The select is sampled in the same cycle as each input strobe, so the law may change from one sample to the next.
- R3: `enc_valid_o` equals `enc_valid_i` delayed by one clock. `enc_code_o` keeps its value in any cycle that follows one with no encode strobe.
- R4: `dec_valid_o` equals `dec_valid_i` delayed by one clock. `dec_sample_o` keeps its value in any cycle that follows one with no decode strobe.
- R5: Bit 7 of every code is the sign, with 1 meaning positive, in both laws. The encoder sets bit 7 to 1 exactly when the sample is non-negative. Decoding a code whose bit 7 is 1 never gives a negative sample.
- R6: mu-law encode works as follows. Take magnitude |s|, limit it to 8158, and add 33 to get b. The segment e (0..7) is the position of the leading one of b minus 5. The mantissa is bits e+4..e+1 of b. The code is the bitwise inverse of {negative, e[2:0], mantissa[3:0]}. So 8191 gives 8'h80, -8192 gives 8'h00, 0 gives 8'hFF and -1 gives 8'h7E.
- R7: mu-law decode inverts the code to get {n, e, m}. The magnitude is ((2m+33)<<e)-33, and it is negated when n is 1. Codes 8'hFF and 8'h7F both decode to 0, and 8'h80 decodes to 8031.
- R8: A-law encode uses x = sample[13:1]. The magnitude is x for x>=0 and -x-1 otherwise. A magnitude below 32 uses segment 0 with mantissa mag[4:1]. Otherwise the segment is the position of the leading one minus 4, and the mantissa is the four bits below that leading one. The code is {positive, seg, mant} XOR 8'h55. So 8191 gives 8'hAA, -8192 gives 8'h2A, 0 gives 8'hD5 and -2 gives 8'h55.
- R9: A-law decode first XORs the code with 8'h55 to get {p, e, m}. The 13-bit magnitude is 2m+1 for e=0 and (2m+33)<<(e-1) otherwise. It is negated when p is 0, and the result is output shifted left by one, so bit 0 is 0. 8'hD5 decodes to 2 and 8'h55 decodes to -2.
- R10: The two paths are independent. A strobe on one path changes neither the valid flag nor the data of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alaw_sel_i | input | 1 | Law select: 0 mu-law, 1 A-law |
| enc_valid_i | input | 1 | Encode strobe |
| enc_sample_i | input | 14 | Linear sample to encode, two's complement |
| enc_valid_o | output | 1 | Encoded code valid |
| enc_code_o | output | 8 | Companded code |
| dec_valid_i | input | 1 | Decode strobe |
| dec_code_i | input | 8 | Companded code to decode |
| dec_valid_o | output | 1 | Decoded sample valid |
| dec_sample_o | output | 14 | Linear sample, two's complement |

## Verification
An encode and a decode can land in the same cycle, and the law select can change on every cycle between them. The bench sweeps all 16384 samples and cycles through all 256 codes with both strobes raised together. The law alternates on each cycle, and each sample is swept twice, once in each law. Each output is compared, one clock later, with an arithmetic model of the law that was in force when that input was taken. Short phases that strobe only one path then confirm that the other path's valid flag drops while its data stays put.

// File: rtl/compander_pkg.sv
package compander_pkg;
  localparam int LIN_W   = 14;
  localparam int CODE_W  = 8;
  localparam int MU_BIAS = 33;
  localparam int MU_CLIP = 8158;
  localparam logic [CODE_W-1:0] A_FLIP = 8'h55;
  typedef logic [LIN_W-1:0]  lin_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef enum logic {LAW_MU = 1'b0, LAW_A = 1'b1} law_e;
endpackage

// File: rtl/seg_find.sv
module seg_find #(
  parameter int W  = 8,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  v_i,
  output logic [PW-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (v_i[i]) pos_o = PW'(i);
    end
  end
endmodule

// File: rtl/compander_enc.sv
module compander_enc
  import compander_pkg::*;
(
  input  lin_t  sample_i,
  input  law_e  law_i,
  output code_t code_o
);
  // mu-law
  logic        mu_neg;
  logic [13:0] mu_mag, mu_clip;
  logic [12:0] mu_b;
  logic [2:0]  mu_seg;
  logic [3:0]  mu_mant;
  code_t       mu_code;

  assign mu_neg  = sample_i[LIN_W-1];
  assign mu_mag  = mu_neg ? 14'(~sample_i + 14'd1) : sample_i;
  assign mu_clip = (mu_mag > 14'(MU_CLIP)) ? 14'(MU_CLIP) : mu_mag;
  assign mu_b    = 13'(mu_clip) + 13'(MU_BIAS);

  seg_find #(.W(8)) u_mu_seg (.v_i(mu_b[12:5]), .pos_o(mu_seg));

  assign mu_mant = 4'(mu_b >> (4'(mu_seg) + 4'd1));
  assign mu_code = ~{mu_neg, mu_seg, mu_mant};

  // A-law on the upper 13 bits
  logic [12:0] a_x;
  logic        a_neg;
  logic [11:0] a_mag;
  logic [2:0]  a_pos, a_seg;
  logic [3:0]  a_mant;
  code_t       a_code;

  assign a_x   = sample_i[LIN_W-1:1];
  assign a_neg = a_x[12];
  assign a_mag = a_neg ? ~a_x[11:0] : a_x[11:0];

  seg_find #(.W(7)) u_a_seg (.v_i(a_mag[11:5]), .pos_o(a_pos));

  assign a_seg  = (|a_mag[11:5]) ? a_pos + 3'd1 : 3'd0;
  assign a_mant = 4'(a_mag >> ((a_seg == 3'd0) ? 3'd1 : a_seg));
  assign a_code = {~a_neg, a_seg, a_mant} ^ A_FLIP;

  assign code_o = (law_i == LAW_A) ? a_code : mu_code;
endmodule

// File: rtl/compander_dec.sv
module compander_dec
  import compander_pkg::*;
(
  input  code_t code_i,
  input  law_e  law_i,
  output lin_t  sample_o
);
  code_t       mu_c;
  logic [13:0] mu_t, mu_mag;
  lin_t        mu_s;

  assign mu_c   = ~code_i;
  assign mu_t   = (14'({mu_c[3:0], 1'b1}) + 14'd32) << mu_c[6:4];
  assign mu_mag = mu_t - 14'(MU_BIAS);
  assign mu_s   = mu_c[7] ? 14'(~mu_mag + 14'd1) : mu_mag;

  code_t       a_c;
  logic [12:0] a_mag, a_v;

  assign a_c   = code_i ^ A_FLIP;
  assign a_mag = (a_c[6:4] == 3'd0) ? 13'({a_c[3:0], 1'b1})
               : (13'({a_c[3:0], 1'b1}) + 13'd32) << (a_c[6:4] - 3'd1);
  assign a_v   = a_c[7] ? a_mag : 13'(~a_mag + 13'd1);

  assign sample_o = (law_i == LAW_A) ? {a_v, 1'b0} : mu_s;
endmodule

// File: rtl/pcm_compander.sv
module pcm_compander
  import compander_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        alaw_sel_i,
  input  logic        enc_valid_i,
  input  logic [13:0] enc_sample_i,
  output logic        enc_valid_o,
  output logic [7:0]  enc_code_o,
  input  logic        dec_valid_i,
  input  logic [7:0]  dec_code_i,
  output logic        dec_valid_o,
  output logic [13:0] dec_sample_o
);
  law_e  law;
  code_t enc_c;
  lin_t  dec_s;

  assign law = alaw_sel_i ? LAW_A : LAW_MU;

  compander_enc u_enc (.sample_i(enc_sample_i), .law_i(law), .code_o(enc_c));
  compander_dec u_dec (.code_i(dec_code_i), .law_i(law), .sample_o(dec_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_valid_o <= 1'b0;
      enc_code_o  <= '0;
    end else begin
      enc_valid_o <= enc_valid_i;
      if (enc_valid_i) enc_code_o <= enc_c;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o  <= 1'b0;
      dec_sample_o <= '0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) dec_sample_o <= dec_s;
    end
  end
endmodule

// File: rtl/compander_chk.sv
module compander_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        alaw_sel_i,
  input logic        enc_valid_i,
  input logic        enc_sign_i,
  input logic        enc_valid_o,
  input logic [7:0]  enc_code_o,
  input logic        dec_valid_i,
  input logic        dec_pos_i,
  input logic        dec_valid_o,
  input logic [13:0] dec_sample_o
);
  a_r1_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |-> (!enc_valid_o && !dec_valid_o));

  a_r3_enc_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> enc_valid_o);
  a_r3_enc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_valid_i |=> (!enc_valid_o && $stable(enc_code_o)));

  a_r4_dec_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i |=> dec_valid_o);
  a_r4_dec_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> (!dec_valid_o && $stable(dec_sample_o)));

  a_r5_enc_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_valid_i |=> (enc_code_o[7] == !$past(enc_sign_i)));
  a_r5_dec_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_pos_i) |=> !dec_sample_o[13]);

  a_r9_alaw_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && alaw_sel_i) |=> !dec_sample_o[0]);
endmodule

bind pcm_compander compander_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .alaw_sel_i(alaw_sel_i),
  .enc_valid_i(enc_valid_i), .enc_sign_i(enc_sample_i[13]),
  .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
  .dec_valid_i(dec_valid_i), .dec_pos_i(dec_code_i[7]),
  .dec_valid_o(dec_valid_o), .dec_sample_o(dec_sample_o)
);

// File: tb/pcm_compander_test.sv
module pcm_compander_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic alaw_sel_i = 1'b0;
  logic enc_valid_i = 1'b0, dec_valid_i = 1'b0;
  logic [13:0] enc_sample_i = '0;
  logic [7:0]  dec_code_i = '0;
  logic enc_valid_o, dec_valid_o;
  logic [7:0]  enc_code_o;
  logic [13:0] dec_sample_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  pcm_compander uut (
    .clk_i(clk), .rst_ni(rst_ni), .alaw_sel_i(alaw_sel_i),
    .enc_valid_i(enc_valid_i), .enc_sample_i(enc_sample_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_sample_o(dec_sample_o)
  );

  function automatic int mu_enc(int s);
    int mag, b, seg, code;
    mag = (s < 0) ? -s : s;
    if (mag > 8158) mag = 8158;
    b = mag + 33;
    seg = 0;
    while (b >= (64 << seg)) seg++;
    code = ((s < 0) ? 128 : 0) | (seg << 4) | ((b >> (seg + 1)) & 15);
    return (~code) & 255;
  endfunction

  function automatic int mu_dec(int c);
    int x, mag;
    x = (~c) & 255;
    mag = (((2 * (x & 15)) + 33) << ((x >> 4) & 7)) - 33;
    return (x & 128) ? -mag : mag;
  endfunction

  function automatic int a_enc(int s);
    int x, mag, seg, mant, p;
    x = s >>> 1;
    p = (x >= 0) ? 1 : 0;
    mag = p ? x : -x - 1;
    if (mag < 32) begin
      seg = 0; mant = (mag >> 1) & 15;
    end else begin
      seg = 1;
      while (mag >= (32 << seg)) seg++;
      mant = (mag >> seg) & 15;
    end
    return ((p << 7) | (seg << 4) | mant) ^ 8'h55;
  endfunction

  function automatic int a_dec(int c);
    int x, e, m, mag;
    x = c ^ 8'h55;
    e = (x >> 4) & 7; m = x & 15;
    mag = (e == 0) ? 2 * m + 1 : (2 * m + 33) << (e - 1);
    return 2 * ((x & 128) ? mag : -mag);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // One encode and one decode in the same cycle, explicit expectations
  task automatic pair(bit law, int s, int c, int exp_code, int exp_lin, string req);
    @(negedge clk);
    alaw_sel_i = law; enc_valid_i = 1; dec_valid_i = 1;
    enc_sample_i = 14'(s); dec_code_i = 8'(c);
    @(negedge clk);
    enc_valid_i = 0; dec_valid_i = 0;
    chk(int'(enc_code_o) == exp_code, req, enc_code_o, exp_code);
    chk(int'($signed(dec_sample_o)) == exp_lin, req, $signed(dec_sample_o), exp_lin);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int ps, pc, plaw;
    bit have;
    repeat (3) @(negedge clk);
    chk(!enc_valid_o && !dec_valid_o, "R1", enc_valid_o + dec_valid_o, 0);
    rst_ni = 1;

    // mu-law endpoints (R6, R7)
    pair(0, 8191, 8'hFF, 8'h80, 0, "R6/R7");
    pair(0, -8192, 8'h7F, 8'h00, 0, "R6/R7");
    pair(0, 0, 8'h80, 8'hFF, 8031, "R6/R7");
    pair(0, -1, 8'h00, 8'h7E, -8031, "R6/R7");
    // A-law endpoints (R8, R9)
    pair(1, 8191, 8'hD5, 8'hAA, 2, "R8/R9");
    pair(1, -8192, 8'h55, 8'h2A, -2, "R8/R9");
    pair(1, 0, 8'hAA, 8'hD5, 8064, "R8/R9");
    pair(1, -2, 8'h2A, 8'h55, -8064, "R8/R9");

    // Idle: valids drop, data holds (R3, R4)
    @(negedge clk);
    chk(!enc_valid_o, "R3", enc_valid_o, 0);
    chk(enc_code_o == 8'h55, "R3", enc_code_o, 8'h55);
    chk(!dec_valid_o, "R4", dec_valid_o, 0);
    chk($signed(dec_sample_o) == -8064, "R4", $signed(dec_sample_o), -8064);

    // Full sweep, both paths each cycle, law toggling every cycle (R2, R5, R10)
    have = 0; ps = 0; pc = 0; plaw = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 16384; i++) begin
        @(negedge clk);
        if (have) begin
          int ec, el;
          ec = plaw ? a_enc(ps) : mu_enc(ps);
          el = plaw ? a_dec(pc) : mu_dec(pc);
          chk(enc_valid_o && dec_valid_o, "R3/R4", enc_valid_o + dec_valid_o, 2);
          chk(int'(enc_code_o) == ec, plaw ? "R2/R8" : "R2/R6", enc_code_o, ec);
          chk(int'($signed(dec_sample_o)) == el, plaw ? "R2/R9" : "R2/R7",
              $signed(dec_sample_o), el);
          chk(enc_code_o[7] == (ps >= 0), "R5", enc_code_o[7], ps >= 0);
        end
        ps = i - 8192; pc = (i * 37 + pass) & 255; plaw = (i ^ pass) & 1;
        alaw_sel_i = plaw[0]; enc_valid_i = 1; dec_valid_i = 1;
        enc_sample_i = 14'(ps); dec_code_i = 8'(pc);
        have = 1;
      end
    end
    @(negedge clk);
    enc_valid_i = 0; dec_valid_i = 0;

    // Encode only: decode side must not move (R10)
    pair(0, 100, 8'h12, mu_enc(100), mu_dec(8'h12), "R10");
    @(negedge clk);
    enc_valid_i = 1; enc_sample_i = 14'(-300); alaw_sel_i = 1;
    @(negedge clk);
    enc_valid_i = 0;
    chk(enc_valid_o && int'(enc_code_o) == a_enc(-300), "R10", enc_code_o, a_enc(-300));
    chk(!dec_valid_o, "R10", dec_valid_o, 0);
    chk($signed(dec_sample_o) == mu_dec(8'h12), "R10", $signed(dec_sample_o), mu_dec(8'h12));

    // Decode only: encode side must not move (R10)
    dec_valid_i = 1; dec_code_i = 8'h9C; alaw_sel_i = 0;
    @(negedge clk);
    dec_valid_i = 0;
    chk(dec_valid_o && $signed(dec_sample_o) == mu_dec(8'h9C), "R10",
        $signed(dec_sample_o), mu_dec(8'h9C));
    chk(!enc_valid_o, "R10", enc_valid_o, 0);
    chk(int'(enc_code_o) == a_enc(-300), "R10", enc_code_o, a_enc(-300));

    // Reset mid-stream (R1)
    enc_valid_i = 1; dec_valid_i = 1;
    @(negedge clk);
    rst_ni = 0;
    #1ns;
    chk(!enc_valid_o && !dec_valid_o, "R1", enc_valid_o + dec_valid_o, 0);
    enc_valid_i = 0; dec_valid_i = 0;
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    finish_run();
  end
endmodule